// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block sits in one sub-partition of a many-threaded processor and chooses, every clock, which warp issues next. A warp is a group of 32 lockstep threads, so one issue event stands for all 32 threads. There is a fixed pool of warp slots. Each slot has a small instruction queue that the front end fills, and a pending bit for every architectural register of that warp. A register is pending while a write to it is still in flight. A warp whose head instruction reads or writes a pending register is stalled. Every other active warp with a queued instruction is eligible to issue.

Among the eligible warps the scheduler picks the oldest one. Warps that became active in the same cycle are ordered by a rotating pointer. The picked warp issues its head instruction. If the next queued instruction is independent of both the head and every pending register, that instruction issues in the same event. Arithmetic results retire after a fixed internal latency. Load results retire when the memory side returns a completion tagged with warp and register. A warp that has been told it is finished is released only after its queue is empty and all of its outstanding writes have retired.

Top module: `warp_issue_sched`

## Requirements
- R1: After a synchronous reset, `iss_vld` and `done_vld` are low until a started warp with a queued instruction becomes eligible.
- R2: A warp that has not been started, has an empty queue, or has a stalled head is never issued, and `iss_vld` stays low in any cycle in which no warp is eligible.
- R3: When several warps are eligible in one cycle, the one started earliest wins, even when the rotating pointer would favour a younger one.
- R4: Warps started in the same cycle are served in rotating order, beginning at the slot after the last warp that issued. For example, if slot 4 issues last and slots 1, 3 and 6 then tie, the order is 6, 1, 3.
- R5: The instruction word has five fields: bit 12 marks a load, bit 11 enables a register write, bits 10:8 name the destination register, and bits 7:0 are a mask of the source registers read. When the second queued instruction reads and writes no pending register and no register written by the head, both instructions issue together. `iss_dual` is then 1, `iss_word0` carries the head and `iss_word1` carries the second instruction.
- R6: When the second instruction reads the head's destination, or reads a pending register, only the head issues (`iss_dual`=0).
- R7: After a load issues, independent later instructions of the same warp keep issuing. An instruction that reads the load's destination stalls until the matching completion. A completion sampled at clock edge X lets it issue at edge X+1.
- R8: An instruction that reads the destination of an arithmetic instruction issues exactly MATH_LAT (default 6) cycles after that producer issues.
- R9: After `warp_exit` for a started warp, `done_vld` pulses for one cycle with that warp in `done_warp` only once its queue is empty and all its pending writes have retired. The slot then ignores queued instructions until it is started again.
- R10: A load completion whose warp id or register id does not match a pending load has no effect on any stalled warp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| warp_start | input | 16 | Per-slot pulse that makes a free slot active |
| warp_exit | input | 16 | Per-slot pulse: this warp will receive no more instructions |
| ins_wr | input | 1 | Writes `ins_word` into the queue of `ins_warp` |
| ins_warp | input | 4 | Target slot of the instruction write |
| ins_word | input | 13 | Instruction descriptor (fields in R5) |
| ld_done_vld | input | 1 | Load completion strobe |
| ld_done_warp | input | 4 | Warp of the completing load |
| ld_done_reg | input | 3 | Destination register of the completing load |
| iss_vld | output | 1 | Issue strobe |
| iss_warp | output | 4 | Warp that issued |
| iss_dual | output | 1 | Two instructions issued |
| iss_word0 | output | 13 | First issued instruction |
| iss_word1 | output | 13 | Second issued instruction, valid when `iss_dual` is 1 |
| done_vld | output | 1 | Warp release pulse |
| done_warp | output | 4 | Released warp |

## Verification
Age ordering and the rotating pointer can both apply in the same selection cycle. The pointer only decides among warps of equal age, so when an older warp and a younger one become eligible together, age has to win. The bench arranges this case. A younger warp's dependent arithmetic instruction unblocks in exactly the cycle in which a freshly written instruction of an older warp becomes visible. The older warp issued last, so the pointer alone would pick the younger one. The bench passes the case only if the older warp issues in that cycle and the younger warp issues in the next.

// File: rtl/wsch_pkg.sv
package wsch_pkg;
  localparam int NUM_WARPS = 16;
  localparam int NUM_REGS  = 8;
  localparam int WARP_W    = $clog2(NUM_WARPS);
  localparam int REG_W     = $clog2(NUM_REGS);

  typedef struct packed {
    logic             is_load;
    logic             wr_en;
    logic [REG_W-1:0] dst;
    logic [NUM_REGS-1:0] src;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  function automatic logic [NUM_REGS-1:0] dst_mask(input instr_t d);
    return d.wr_en ? (NUM_REGS'(1) << d.dst) : '0;
  endfunction

  // true when an instruction touches a register that is still pending
  function automatic logic hits(input instr_t d, input logic [NUM_REGS-1:0] busy_regs);
    return |((d.src | dst_mask(d)) & busy_regs);
  endfunction
endpackage

// File: rtl/wsch_iqueue.sv
module wsch_iqueue
  import wsch_pkg::*;
#(
  parameter int NW    = NUM_WARPS,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WARP_W-1:0] wr_warp,
  input  instr_t            wr_data,
  input  logic [WARP_W-1:0] pop_warp,
  input  logic [1:0]        pop_cnt,
  output instr_t            head0 [NW],
  output instr_t            head1 [NW],
  output logic [NW-1:0]     has1,
  output logic [NW-1:0]     has2
);
  localparam int PW = $clog2(DEPTH);

  for (genvar w = 0; w < NW; w++) begin : g_q
    instr_t         mem [DEPTH];
    logic [PW-1:0]  rp, wp;
    logic [PW:0]    cnt;
    logic           push;
    logic [1:0]     pop;

    assign push = wr_en && (wr_warp == WARP_W'(w)) && (cnt != (PW+1)'(DEPTH));
    assign pop  = (pop_warp == WARP_W'(w)) ? pop_cnt : 2'd0;

    always_ff @(posedge clk) begin
      if (push) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        rp  <= '0;
        wp  <= '0;
        cnt <= '0;
      end else begin
        wp  <= wp + PW'(push);
        rp  <= rp + PW'(pop);
        cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
      end
    end

    assign head0[w] = mem[rp];
    assign head1[w] = mem[rp + PW'(1)];
    assign has1[w]  = (cnt != '0);
    assign has2[w]  = (cnt >= (PW+1)'(2));

    // R5
    pop_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      (PW+1)'(pop) <= cnt);
  end
endmodule

// File: rtl/wsch_scoreboard.sv
module wsch_scoreboard
  import wsch_pkg::*;
#(
  parameter int NW       = NUM_WARPS,
  parameter int MATH_LAT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_vld,
  input  logic [WARP_W-1:0] upd_warp,
  input  logic              upd_two,
  input  instr_t            upd_d0,
  input  instr_t            upd_d1,
  input  logic              ld_vld,
  input  logic [WARP_W-1:0] ld_warp,
  input  logic [REG_W-1:0]  ld_reg,
  output logic [NUM_REGS-1:0] pend [NW],
  output logic [NW-1:0]     busy
);
  localparam int STAGES = MATH_LAT - 1;

  typedef struct packed {
    logic              v;
    logic [WARP_W-1:0] w;
    logic [REG_W-1:0]  r;
  } tag_t;

  tag_t pipe [STAGES][2];
  tag_t entry [2];
  logic [NUM_REGS-1:0] pend_nx [NW];
  logic [NW*NUM_REGS-1:0] pend_flat;

  always_comb begin
    entry[0] = '{v: upd_vld && upd_d0.wr_en && !upd_d0.is_load, w: upd_warp, r: upd_d0.dst};
    entry[1] = '{v: upd_vld && upd_two && upd_d1.wr_en && !upd_d1.is_load, w: upd_warp, r: upd_d1.dst};
  end

  always_comb begin
    for (int w = 0; w < NW; w++) begin
      pend_nx[w] = pend[w];
      for (int l = 0; l < 2; l++)
        if (pipe[STAGES-1][l].v && pipe[STAGES-1][l].w == WARP_W'(w))
          pend_nx[w][pipe[STAGES-1][l].r] = 1'b0;
      if (ld_vld && ld_warp == WARP_W'(w)) pend_nx[w][ld_reg] = 1'b0;
      if (upd_vld && upd_warp == WARP_W'(w)) begin
        if (upd_d0.wr_en) pend_nx[w][upd_d0.dst] = 1'b1;
        if (upd_two && upd_d1.wr_en) pend_nx[w][upd_d1.dst] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < NW; w++) pend[w] <= '0;
      for (int s = 0; s < STAGES; s++) begin
        pipe[s][0] <= '0;
        pipe[s][1] <= '0;
      end
    end else begin
      for (int w = 0; w < NW; w++) pend[w] <= pend_nx[w];
      pipe[0][0] <= entry[0];
      pipe[0][1] <= entry[1];
      for (int s = 1; s < STAGES; s++) begin
        pipe[s][0] <= pipe[s-1][0];
        pipe[s][1] <= pipe[s-1][1];
      end
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_busy
    assign busy[w] = |pend[w];
    assign pend_flat[w*NUM_REGS +: NUM_REGS] = pend[w];
  end

  // R7
  pend_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_vld |=> ($countones(pend_flat) <= $past($countones(pend_flat))));
endmodule

// File: rtl/wsch_pick.sv
module wsch_pick
  import wsch_pkg::*;
#(
  parameter int NW = NUM_WARPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NW-1:0]     start,
  input  logic [NW-1:0]     active,
  input  logic [NW-1:0]     elig,
  output logic              pick_vld,
  output logic [WARP_W-1:0] pick_id
);
  // older[j][i] set: warp j became active before warp i
  logic [NW-1:0] older [NW];
  logic [NW-1:0] cand;
  logic [WARP_W-1:0] rr;
  logic asym_bad;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      logic [NW-1:0] col;
      for (int j = 0; j < NW; j++) col[j] = older[j][i];
      cand[i] = elig[i] && !(|(elig & col));
    end
  end

  always_comb begin
    int idx;
    pick_vld = 1'b0;
    pick_id  = '0;
    for (int k = 0; k < NW; k++) begin
      idx = (int'(rr) + k) % NW;
      if (!pick_vld && cand[idx]) begin
        pick_vld = 1'b1;
        pick_id  = WARP_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr <= '0;
      for (int i = 0; i < NW; i++) older[i] <= '0;
    end else begin
      if (pick_vld) rr <= (pick_id == WARP_W'(NW-1)) ? '0 : pick_id + WARP_W'(1);
      for (int i = 0; i < NW; i++)
        if (start[i])
          for (int j = 0; j < NW; j++) begin
            older[i][j] <= 1'b0;
            if (!start[j]) older[j][i] <= active[j];
          end
    end
  end

  always_comb begin
    asym_bad = 1'b0;
    for (int i = 0; i < NW; i++)
      for (int j = 0; j < NW; j++)
        if (older[i][j] && older[j][i]) asym_bad = 1'b1;
  end

  // R3
  age_asym_chk: assert property (@(posedge clk) disable iff (rst) !asym_bad);
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsch_pkg::*;
#(
  parameter int QUEUE_DEPTH = 4,
  parameter int MATH_LAT    = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WARPS-1:0] warp_start,
  input  logic [NUM_WARPS-1:0] warp_exit,
  input  logic                 ins_wr,
  input  logic [WARP_W-1:0]    ins_warp,
  input  logic [INSTR_W-1:0]   ins_word,
  input  logic                 ld_done_vld,
  input  logic [WARP_W-1:0]    ld_done_warp,
  input  logic [REG_W-1:0]     ld_done_reg,
  output logic                 iss_vld,
  output logic [WARP_W-1:0]    iss_warp,
  output logic                 iss_dual,
  output logic [INSTR_W-1:0]   iss_word0,
  output logic [INSTR_W-1:0]   iss_word1,
  output logic                 done_vld,
  output logic [WARP_W-1:0]    done_warp
);
  localparam int NW = NUM_WARPS;

  instr_t head0 [NW];
  instr_t head1 [NW];
  logic [NUM_REGS-1:0] pend [NW];
  logic [NW-1:0] has1, has2, busy, elig, fin, slot_vld, slot_exit, new_start;
  logic pick_vld, dual_ok, fin_vld;
  logic [WARP_W-1:0] pick_id, fin_id;
  logic [1:0] pop_cnt;
  instr_t h0, h1;

  wsch_iqueue #(.NW(NW), .DEPTH(QUEUE_DEPTH)) queue_i (
    .clk, .rst, .wr_en(ins_wr), .wr_warp(ins_warp), .wr_data(instr_t'(ins_word)),
    .pop_warp(pick_id), .pop_cnt, .head0, .head1, .has1, .has2);

  wsch_scoreboard #(.NW(NW), .MATH_LAT(MATH_LAT)) sb_i (
    .clk, .rst, .upd_vld(pick_vld), .upd_warp(pick_id), .upd_two(dual_ok),
    .upd_d0(h0), .upd_d1(h1), .ld_vld(ld_done_vld), .ld_warp(ld_done_warp),
    .ld_reg(ld_done_reg), .pend, .busy);

  wsch_pick #(.NW(NW)) pick_i (
    .clk, .rst, .start(new_start), .active(slot_vld), .elig, .pick_vld, .pick_id);

  assign new_start = warp_start & ~slot_vld;

  always_comb begin
    for (int i = 0; i < NW; i++) begin
      elig[i] = slot_vld[i] && has1[i] && !hits(head0[i], pend[i]);
      fin[i]  = slot_vld[i] && slot_exit[i] && !has1[i] && !busy[i];
    end
    h0 = head0[pick_id];
    h1 = head1[pick_id];
    dual_ok = pick_vld && has2[pick_id] && !hits(h1, pend[pick_id]) && !hits(h1, dst_mask(h0));
    pop_cnt = !pick_vld ? 2'd0 : (dual_ok ? 2'd2 : 2'd1);
    fin_vld = 1'b0;
    fin_id  = '0;
    for (int i = NW-1; i >= 0; i--)
      if (fin[i]) begin
        fin_vld = 1'b1;
        fin_id  = WARP_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_vld  <= '0;
      slot_exit <= '0;
      iss_vld   <= 1'b0;
      iss_warp  <= '0;
      iss_dual  <= 1'b0;
      iss_word0 <= '0;
      iss_word1 <= '0;
      done_vld  <= 1'b0;
      done_warp <= '0;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (fin_vld && fin_id == WARP_W'(i)) begin
          slot_vld[i]  <= 1'b0;
          slot_exit[i] <= 1'b0;
        end else if (new_start[i]) begin
          slot_vld[i]  <= 1'b1;
          slot_exit[i] <= 1'b0;
        end else if (warp_exit[i] && slot_vld[i]) begin
          slot_exit[i] <= 1'b1;
        end
      end
      iss_vld   <= pick_vld;
      iss_warp  <= pick_id;
      iss_dual  <= dual_ok;
      iss_word0 <= h0;
      iss_word1 <= dual_ok ? h1 : '0;
      done_vld  <= fin_vld;
      done_warp <= fin_id;
    end
  end

  // R2
  no_idle_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (elig == '0) |=> !iss_vld);
  // R3
  pick_elig_chk: assert property (@(posedge clk) disable iff (rst)
    pick_vld |-> elig[pick_id]);
  // R5
  dual_flag_chk: assert property (@(posedge clk) disable iff (rst)
    iss_dual |-> iss_vld);
  // R9
  done_clean_chk: assert property (@(posedge clk) disable iff (rst)
    done_vld |-> !busy[done_warp]);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_vld |=> !(done_vld && done_warp == $past(done_warp)));
endmodule

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;
  import wsch_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_WARPS-1:0] warp_start = '0, warp_exit = '0;
  logic ins_wr = 1'b0;
  logic [WARP_W-1:0] ins_warp = '0;
  logic [INSTR_W-1:0] ins_word = '0;
  logic ld_done_vld = 1'b0;
  logic [WARP_W-1:0] ld_done_warp = '0;
  logic [REG_W-1:0] ld_done_reg = '0;
  logic iss_vld, iss_dual, done_vld;
  logic [WARP_W-1:0] iss_warp, done_warp;
  logic [INSTR_W-1:0] iss_word0, iss_word1;

  int cyc = 0;
  int total = 0, fails = 0;
  int nlog = 0, ndone = 0;
  int lg_cyc [32], lg_warp [32], lg_dual [32];
  logic [INSTR_W-1:0] lg_d0 [32], lg_d1 [32];
  int dn_cyc [8], dn_warp [8];

  always #5 clk = ~clk;

  warp_issue_sched dut_i (
    .clk, .rst, .warp_start, .warp_exit, .ins_wr, .ins_warp, .ins_word,
    .ld_done_vld, .ld_done_warp, .ld_done_reg, .iss_vld, .iss_warp, .iss_dual,
    .iss_word0, .iss_word1, .done_vld, .done_warp);

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst) begin
      nlog = 0;
      ndone = 0;
    end else begin
      if (iss_vld && nlog < 32) begin
        lg_cyc[nlog] = cyc; lg_warp[nlog] = int'(iss_warp); lg_dual[nlog] = int'(iss_dual);
        lg_d0[nlog] = iss_word0; lg_d1[nlog] = iss_word1;
        nlog++;
      end
      if (done_vld && ndone < 8) begin
        dn_cyc[ndone] = cyc; dn_warp[ndone] = int'(done_warp);
        ndone++;
      end
    end
  end

  function automatic logic [INSTR_W-1:0] mk(input logic ld, input logic wr, input int dst,
                                             input logic [NUM_REGS-1:0] src);
    return {ld, wr, REG_W'(dst), src};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input int w, input logic [INSTR_W-1:0] word);
    ins_wr = 1'b1; ins_warp = WARP_W'(w); ins_word = word;
    step(1);
    ins_wr = 1'b0;
  endtask

  task automatic start(input logic [NUM_WARPS-1:0] m);
    warp_start = m;
    step(1);
    warp_start = '0;
  endtask

  task automatic ldc(input int w, input int r, output int edge_idx);
    ld_done_vld = 1'b1; ld_done_warp = WARP_W'(w); ld_done_reg = REG_W'(r);
    step(1);
    edge_idx = cyc;
    ld_done_vld = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 outputs idle after reset
    chk("R1 iss_vld after reset", int'(iss_vld), 0);
    chk("R1 done_vld after reset", int'(done_vld), 0);
  endtask

  // R5 dual issue, R6 head-dependent second, R8 math latency
  task automatic t_dual();
    logic [INSTR_W-1:0] a, b, c, d;
    a = mk(0, 1, 1, 8'h00); b = mk(0, 1, 2, 8'h08);
    c = mk(0, 1, 4, 8'h00); d = mk(0, 0, 0, 8'h10);
    do_reset();
    put(0, a); put(0, b); put(0, c); put(0, d);
    step(2);
    chk("R2 unstarted warp not issued", nlog, 0);
    start(16'h0001);
    step(14);
    chk("R8 issue count", nlog, 3);
    chk("R5 dual flag", lg_dual[0], 1);
    chk("R5 first word", int'(lg_d0[0]), int'(a));
    chk("R5 second word", int'(lg_d1[0]), int'(b));
    chk("R6 second reads head dst -> single", lg_dual[1], 0);
    chk("R6 head issued next cycle", lg_cyc[1] - lg_cyc[0], 1);
    chk("R8 dependent math gap", lg_cyc[2] - lg_cyc[1], 6);
    chk("R8 dependent word", int'(lg_d0[2]), int'(d));
  endtask

  // R7 load scoreboarding, R6 pending second, R10 unrelated completions
  task automatic t_load();
    logic [INSTR_W-1:0] m, n, p, q;
    int x;
    m = mk(1, 1, 2, 8'h00); n = mk(0, 0, 0, 8'h01);
    p = mk(0, 1, 6, 8'h01); q = mk(0, 0, 0, 8'h04);
    do_reset();
    put(0, m); put(0, n); put(0, p); put(0, q);
    start(16'h0001);
    step(12);
    chk("R7 issues before stall", nlog, 2);
    chk("R7 load plus independent dual", lg_dual[0], 1);
    chk("R7 independent after load", int'(lg_d0[1]), int'(p));
    chk("R6 second on pending reg -> single", lg_dual[1], 0);
    ldc(1, 2, x);
    ldc(0, 5, x);
    step(4);
    chk("R10 wrong tags release nothing", nlog, 2);
    chk("R2 no strobe while stalled", int'(iss_vld), 0);
    ldc(0, 2, x);
    step(3);
    chk("R7 dependent issues after completion", nlog, 3);
    chk("R7 completion to issue edge", lg_cyc[2] - x, 1);
    chk("R7 dependent word", int'(lg_d0[2]), int'(q));
  endtask

  // R3 age beats rotating pointer
  task automatic t_age();
    do_reset();
    put(2, mk(0, 1, 1, 8'h00));
    put(2, mk(0, 0, 0, 8'h02));
    start(16'h0200);
    start(16'h0004);
    step(1);
    put(9, mk(0, 0, 0, 8'h00));
    step(3);
    put(9, mk(0, 0, 0, 8'h00));
    step(6);
    chk("R3 issue count", nlog, 4);
    chk("R3 younger first alone", lg_warp[0], 2);
    chk("R3 older lone issue", lg_warp[1], 9);
    chk("R3 older wins collision", lg_warp[2], 9);
    chk("R3 collision cycle", lg_cyc[2] - lg_cyc[0], 6);
    chk("R3 younger follows", lg_warp[3], 2);
    chk("R3 younger cycle", lg_cyc[3] - lg_cyc[0], 7);
  endtask

  // R4 rotating order among equal-age warps
  task automatic t_rr();
    do_reset();
    put(4, mk(0, 0, 0, 8'h00)); put(1, mk(0, 0, 0, 8'h00));
    put(3, mk(0, 0, 0, 8'h00)); put(6, mk(0, 0, 0, 8'h00));
    start(16'h0010);
    start(16'h004A);
    step(8);
    chk("R4 issue count", nlog, 4);
    chk("R4 first", lg_warp[0], 4);
    chk("R4 rotation step 1", lg_warp[1], 6);
    chk("R4 rotation step 2", lg_warp[2], 1);
    chk("R4 rotation step 3", lg_warp[3], 3);
    chk("R4 back to back", lg_cyc[3] - lg_cyc[1], 2);
  endtask

  // R9 release waits for outstanding writes
  task automatic t_done();
    int x;
    do_reset();
    put(7, mk(0, 1, 3, 8'h00));
    start(16'h0080);
    warp_exit = 16'h0080;
    step(1);
    warp_exit = '0;
    step(10);
    chk("R9 one release", ndone, 1);
    chk("R9 released warp", dn_warp[0], 7);
    chk("R9 release after math retire", dn_cyc[0] - lg_cyc[0], 6);
    put(7, mk(0, 0, 0, 8'h00));
    step(4);
    chk("R9 freed slot ignores queue", nlog, 1);
    put(5, mk(1, 1, 1, 8'h00));
    start(16'h0020);
    warp_exit = 16'h0020;
    step(1);
    warp_exit = '0;
    step(8);
    chk("R9 held by pending load", ndone, 1);
    ldc(5, 1, x);
    step(3);
    chk("R9 release after load", ndone, 2);
    chk("R9 load release warp", dn_warp[1], 5);
    chk("R9 load release edge", dn_cyc[1] - x, 1);
  endtask

  initial begin
    #2000000;
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_dual();
    t_load();
    t_age();
    t_rr();
    t_done();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule